// File: doc/BRIEF.md
# Decoded Micro-op Line Packer

This block sits between a one-instruction-per-cycle decoder and the execution back end. When a fetch has missed, the decoder sends each instruction's micro-ops (one to four of them) to the block in a single beat. The block packs them, in the order they arrive, into six-slot lines. A line is closed when its slots are exactly used up. It is also closed when the next instruction would not fit, or when the decoder marks the end of the fill. Each closed line is presented on a write port and also stored in an internal line array.

On the fetch side, a request names a line index. The block spends two cycles reading the whole line. It then moves the line's valid micro-ops into an issue queue, which hands the oldest three micro-ops per cycle to the back end. The block takes a new fetch only when the queue has room for a full line. A flush clears the partial line being filled, the queue and any fetch in progress.

Top module: `uop_line_packer`

## Requirements
- R1: After reset, `wr_en` is 0, `out_valid` is 0, and `fetch_take` is 0 while `fetch_req` is low.
- R2: The micro-ops of accepted beats fill a line from slot 0 upward, in arrival order, with beat lane 0 first. In the cycle after a beat brings the line to exactly six, `wr_en` is high for one cycle and `wr_count` is 6.
- R3: If a beat does not fit in the free slots, the micro-ops of an instruction are never split. In the next cycle the current line is written with `wr_count` equal to its filled slots. The rest of that line is padding. The beat's micro-ops begin a new line at slot 0.
- R4: `fill_end` with `dec_valid` low writes a non-empty partial line in the next cycle. It has no effect on an empty line, and it has no effect when `dec_valid` is high in the same cycle.
- R5: `wr_idx` is 0 for the first line written after reset. It advances by one for each line written and wraps modulo LINES.
- R6: `fetch_take` is high exactly when `fetch_req` is high, no fetch was taken in the previous cycle, `flush` is low, and the queue holds at most BUF_DEPTH-6 micro-ops. This gives at most one line per two cycles.
- R7: The valid micro-ops of a taken line, in slot order, enter the queue at the end of the cycle after `fetch_take`. The line contents are those stored before that cycle's edge. A line enters the store at the edge that ends its `wr_en` cycle, and an index that was never written holds zero micro-ops.
- R8: `out_valid` lane i is high when the queue holds more than i micro-ops. Lane 0 carries the oldest micro-op. Every valid lane is removed at the next edge.
- R9: `flush` discards the partial fill line, the decoder beat and the fetch request of that cycle, and any fetch in progress. The queue is empty in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard fill line, queue and fetch in progress |
| dec_valid | input | 1 | Decoder beat present |
| dec_count | input | 3 | Micro-ops in the beat, 1 to DEC_W |
| dec_uops | input | DEC_W*UOP_W | Beat micro-ops, lane k at bits k*UOP_W |
| fill_end | input | 1 | Close the partial fill line |
| fetch_req | input | 1 | Fetch request |
| fetch_idx | input | $clog2(LINES) | Line index to fetch |
| fetch_take | output | 1 | Request accepted this cycle |
| wr_en | output | 1 | Closed line on the write port |
| wr_idx | output | $clog2(LINES) | Index of the written line |
| wr_count | output | 3 | Valid slots in the written line |
| wr_uops | output | SLOTS*UOP_W | Line slots, slot s at bits s*UOP_W, padding zero |
| out_valid | output | ISSUE_W | Issue lane valids |
| out_uops | output | ISSUE_W*UOP_W | Issue lane micro-ops |

## Verification
The bench builds the block with LINES=4, so the write index wraps many times. A single fill sequence can also overwrite a line that is being fetched in the same cycle. BUF_DEPTH is 8, so the queue admits a new line only when it holds two or fewer micro-ops. This means back-to-back fetches really do stall, whereas the default depth of 12 would never hold one back. Directed beats cover exact fills, spills, ends of fill that are honoured and ends of fill that are ignored. After that, a long random mix of beats, fetches and flushes is compared on every cycle with a queue-based model.

// File: rtl/uop_pack_pkg.sv
package uop_pack_pkg;

  typedef enum logic [1:0] {
    CLOSE_NONE,
    CLOSE_FULL,
    CLOSE_SPILL,
    CLOSE_END
  } close_e;

  function automatic bit beat_spills(input int filled, input int n, input int slots);
    return (filled + n) > slots;
  endfunction

  function automatic int issue_take(input int held, input int lanes);
    return (held < lanes) ? held : lanes;
  endfunction

  function automatic int ring_step(input int ptr, input int inc, input int depth);
    int s;
    s = ptr + inc;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/uop_fill_packer.sv
module uop_fill_packer
  import uop_pack_pkg::*;
#(
  parameter int UOP_W = 16,
  parameter int SLOTS = 6,
  parameter int DEC_W = 4,
  parameter int LINES = 16,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int DCW   = $clog2(DEC_W + 1),
  localparam int LAW   = $clog2(LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   dec_valid,
  input  logic [DCW-1:0]         dec_count,
  input  logic [DEC_W*UOP_W-1:0] dec_uops,
  input  logic                   fill_end,
  output logic                   wr_en,
  output logic [LAW-1:0]         wr_idx,
  output logic [CNT_W-1:0]       wr_count,
  output logic [SLOTS*UOP_W-1:0] wr_uops
);

  logic [CNT_W-1:0] fill_cnt;
  logic [UOP_W-1:0] fill_slot [SLOTS];
  logic [UOP_W-1:0] merged    [SLOTS];
  logic [LAW-1:0]   line_ptr;
  logic             take_beat, spill;
  logic [CNT_W-1:0] base, new_cnt, close_cnt;
  close_e           close_kind;

  always_comb begin
    take_beat = dec_valid && !flush;
    spill     = take_beat && beat_spills(int'(fill_cnt), int'(dec_count), SLOTS);
    base      = spill ? '0 : fill_cnt;
    new_cnt   = base + CNT_W'(dec_count);
    for (int s = 0; s < SLOTS; s++) begin
      merged[s] = fill_slot[s];
      for (int k = 0; k < DEC_W; k++)
        if (take_beat && k < int'(dec_count) && s == int'(base) + k)
          merged[s] = dec_uops[k*UOP_W +: UOP_W];
    end
    if (!take_beat)
      close_kind = (fill_end && !dec_valid && !flush && fill_cnt != '0) ? CLOSE_END : CLOSE_NONE;
    else if (spill)
      close_kind = CLOSE_SPILL;
    else if (int'(new_cnt) == SLOTS)
      close_kind = CLOSE_FULL;
    else
      close_kind = CLOSE_NONE;
    close_cnt = (close_kind == CLOSE_FULL) ? CNT_W'(SLOTS) : fill_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      line_ptr <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_count <= '0;
      wr_uops  <= '0;
      for (int s = 0; s < SLOTS; s++) fill_slot[s] <= '0;
    end else begin
      wr_en <= (close_kind != CLOSE_NONE);
      if (close_kind != CLOSE_NONE) begin
        wr_idx   <= line_ptr;
        line_ptr <= LAW'(ring_step(int'(line_ptr), 1, LINES));
        wr_count <= close_cnt;
        for (int s = 0; s < SLOTS; s++)
          wr_uops[s*UOP_W +: UOP_W] <= (s >= int'(close_cnt)) ? '0 :
                                       (close_kind == CLOSE_FULL) ? merged[s] : fill_slot[s];
      end
      if (flush) begin
        fill_cnt <= '0;
      end else if (take_beat) begin
        fill_cnt <= (close_kind == CLOSE_FULL) ? '0 : new_cnt;
        for (int s = 0; s < SLOTS; s++) fill_slot[s] <= merged[s];
      end else if (close_kind == CLOSE_END) begin
        fill_cnt <= '0;
      end
    end
  end

  assert_write_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_count != '0 && int'(wr_count) <= SLOTS));

  assert_spill_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (close_kind == CLOSE_SPILL) |=> (wr_en && int'(fill_cnt) == int'($past(dec_count))));

  assert_end_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_end && !dec_valid && fill_cnt == '0) |=> !wr_en);

  assert_flush_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!wr_en && fill_cnt == '0));

endmodule

// File: rtl/uop_line_store.sv
module uop_line_store #(
  parameter int UOP_W = 16,
  parameter int SLOTS = 6,
  parameter int LINES = 16,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int LAW   = $clog2(LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [LAW-1:0]         wr_idx,
  input  logic [CNT_W-1:0]       wr_count,
  input  logic [SLOTS*UOP_W-1:0] wr_uops,
  input  logic [LAW-1:0]         rd_idx,
  output logic [CNT_W-1:0]       rd_count,
  output logic [SLOTS*UOP_W-1:0] rd_uops
);

  logic [CNT_W-1:0]       cnt_mem  [LINES];
  logic [SLOTS*UOP_W-1:0] data_mem [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) cnt_mem[i] <= '0;
    end else if (wr_en) begin
      cnt_mem[wr_idx] <= wr_count;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_idx] <= wr_uops;
  end

  assign rd_count = cnt_mem[rd_idx];
  assign rd_uops  = data_mem[rd_idx];

endmodule

// File: rtl/uop_fetch_seq.sv
module uop_fetch_seq #(
  parameter int SLOTS     = 6,
  parameter int LINES     = 16,
  parameter int BUF_DEPTH = 12,
  localparam int LAW = $clog2(LINES),
  localparam int BCW = $clog2(BUF_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           fetch_req,
  input  logic [LAW-1:0] fetch_idx,
  input  logic [BCW-1:0] buf_count,
  output logic           fetch_take,
  output logic [LAW-1:0] rd_idx,
  output logic           push_go
);

  logic busy;
  logic room_ok;

  assign room_ok    = int'(buf_count) <= BUF_DEPTH - SLOTS;
  assign fetch_take = fetch_req && !busy && !flush && room_ok;
  assign push_go    = busy && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rd_idx <= '0;
    end else begin
      busy <= fetch_take;
      if (fetch_take) rd_idx <= fetch_idx;
    end
  end

  assert_half_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_take |=> !fetch_take);

  assert_push_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_take && !$past(fetch_take)) |=> (push_go || flush));

endmodule

// File: rtl/uop_issue_buf.sv
module uop_issue_buf
  import uop_pack_pkg::*;
#(
  parameter int UOP_W     = 16,
  parameter int SLOTS     = 6,
  parameter int ISSUE_W   = 3,
  parameter int BUF_DEPTH = 12,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int BCW   = $clog2(BUF_DEPTH + 1),
  localparam int PW    = $clog2(BUF_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push_go,
  input  logic [CNT_W-1:0]         line_cnt,
  input  logic [SLOTS*UOP_W-1:0]   line_uops,
  output logic [BCW-1:0]           count,
  output logic [ISSUE_W-1:0]       out_valid,
  output logic [ISSUE_W*UOP_W-1:0] out_uops
);

  logic [UOP_W-1:0] mem [BUF_DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  int               pop_n, push_n;

  always_comb begin
    pop_n  = issue_take(int'(count), ISSUE_W);
    push_n = push_go ? int'(line_cnt) : 0;
    for (int i = 0; i < ISSUE_W; i++) begin
      out_valid[i] = i < int'(count);
      out_uops[i*UOP_W +: UOP_W] = mem[PW'(ring_step(int'(rd_ptr), i, BUF_DEPTH))];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (flush) begin
      count  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      count  <= BCW'(int'(count) - pop_n + push_n);
      rd_ptr <= PW'(ring_step(int'(rd_ptr), pop_n, BUF_DEPTH));
      wr_ptr <= PW'(ring_step(int'(wr_ptr), push_n, BUF_DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++)
      if (push_go && !flush && s < int'(line_cnt))
        mem[PW'(ring_step(int'(wr_ptr), s, BUF_DEPTH))] <= line_uops[s*UOP_W +: UOP_W];
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= BUF_DEPTH);

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_valid == '0));

  for (genvar g = 1; g < ISSUE_W; g++) begin : g_lane_chk
    assert_lanes_packed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> out_valid[g-1]);
  end

endmodule

// File: rtl/uop_line_packer.sv
module uop_line_packer #(
  parameter int UOP_W     = 16,
  parameter int SLOTS     = 6,
  parameter int DEC_W     = 4,
  parameter int ISSUE_W   = 3,
  parameter int LINES     = 16,
  parameter int BUF_DEPTH = 12,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int DCW   = $clog2(DEC_W + 1),
  localparam int LAW   = $clog2(LINES),
  localparam int BCW   = $clog2(BUF_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     dec_valid,
  input  logic [DCW-1:0]           dec_count,
  input  logic [DEC_W*UOP_W-1:0]   dec_uops,
  input  logic                     fill_end,
  input  logic                     fetch_req,
  input  logic [LAW-1:0]           fetch_idx,
  output logic                     fetch_take,
  output logic                     wr_en,
  output logic [LAW-1:0]           wr_idx,
  output logic [CNT_W-1:0]         wr_count,
  output logic [SLOTS*UOP_W-1:0]   wr_uops,
  output logic [ISSUE_W-1:0]       out_valid,
  output logic [ISSUE_W*UOP_W-1:0] out_uops
);

  logic [LAW-1:0]         rd_idx;
  logic [CNT_W-1:0]       rd_count;
  logic [SLOTS*UOP_W-1:0] rd_uops;
  logic [BCW-1:0]         buf_count;
  logic                   push_go;

  uop_fill_packer #(.UOP_W(UOP_W), .SLOTS(SLOTS), .DEC_W(DEC_W), .LINES(LINES)) u_fill (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .dec_valid(dec_valid), .dec_count(dec_count), .dec_uops(dec_uops), .fill_end(fill_end),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_count(wr_count), .wr_uops(wr_uops)
  );

  uop_line_store #(.UOP_W(UOP_W), .SLOTS(SLOTS), .LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_count(wr_count), .wr_uops(wr_uops),
    .rd_idx(rd_idx), .rd_count(rd_count), .rd_uops(rd_uops)
  );

  uop_fetch_seq #(.SLOTS(SLOTS), .LINES(LINES), .BUF_DEPTH(BUF_DEPTH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx), .buf_count(buf_count),
    .fetch_take(fetch_take), .rd_idx(rd_idx), .push_go(push_go)
  );

  uop_issue_buf #(.UOP_W(UOP_W), .SLOTS(SLOTS), .ISSUE_W(ISSUE_W), .BUF_DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_go(push_go), .line_cnt(rd_count), .line_uops(rd_uops),
    .count(buf_count), .out_valid(out_valid), .out_uops(out_uops)
  );

endmodule

// File: tb/uop_line_packer_tb.sv
`timescale 1ns/1ps
module uop_line_packer_tb_top;
  localparam int UW = 16, SL = 6, DW = 4, IW = 3, LN = 4, BD = 8, LAW = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, dec_valid = 1'b0, fill_end = 1'b0, fetch_req = 1'b0;
  logic [2:0] dec_count = '0;
  logic [DW*UW-1:0] dec_uops = '0;
  logic [LAW-1:0] fetch_idx = '0;
  logic fetch_take, wr_en;
  logic [LAW-1:0] wr_idx;
  logic [2:0] wr_count;
  logic [SL*UW-1:0] wr_uops;
  logic [IW-1:0] out_valid;
  logic [IW*UW-1:0] out_uops;

  uop_line_packer #(.UOP_W(UW), .SLOTS(SL), .DEC_W(DW), .ISSUE_W(IW), .LINES(LN), .BUF_DEPTH(BD)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dec_valid(dec_valid), .dec_count(dec_count),
    .dec_uops(dec_uops), .fill_end(fill_end), .fetch_req(fetch_req), .fetch_idx(fetch_idx),
    .fetch_take(fetch_take), .wr_en(wr_en), .wr_idx(wr_idx), .wr_count(wr_count),
    .wr_uops(wr_uops), .out_valid(out_valid), .out_uops(out_uops)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, next_val = 1;
  bit done = 0;
  int m_fill[$];
  int m_buf[$];
  bit m_wr_en = 0;
  int m_wr_idx = 0, m_wr_cnt = 0, m_line_ptr = 0;
  int m_wr_dat[SL];
  int m_st_cnt[LN];
  int m_st_dat[LN][SL];
  bit m_busy = 0;
  int m_rd_idx = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_regs();
    chk("R2 R3 R4 wr_en", int'(wr_en), int'(m_wr_en));
    if (m_wr_en) begin
      chk("R5 wr_idx", int'(wr_idx), m_wr_idx);
      chk("R2 R3 R4 wr_count", int'(wr_count), m_wr_cnt);
      for (int s = 0; s < m_wr_cnt; s++)
        chk("R2 R3 wr slot", int'(wr_uops[s*UW +: UW]), m_wr_dat[s]);
    end
    for (int i = 0; i < IW; i++) begin
      chk("R8 R9 out_valid", int'(out_valid[i]), int'(i < m_buf.size()));
      if (i < m_buf.size()) chk("R7 R8 out_uop", int'(out_uops[i*UW +: UW]), m_buf[i]);
    end
  endtask

  task automatic emit(input int q[$]);
    m_wr_en = 1;
    m_wr_idx = m_line_ptr;
    m_line_ptr = (m_line_ptr + 1) % LN;
    m_wr_cnt = q.size();
    for (int s = 0; s < SL; s++) m_wr_dat[s] = (s < q.size()) ? q[s] : 0;
  endtask

  task automatic step(input bit dv, input int dc, input bit fe, input bit fr, input int fi, input bit fl);
    int beat[$];
    int pushed[$];
    bit take;
    @(negedge clk);
    compare_regs();
    dec_valid = dv; dec_count = 3'(dc); fill_end = fe; fetch_req = fr;
    fetch_idx = LAW'(fi); flush = fl;
    for (int k = 0; k < DW; k++) begin
      dec_uops[k*UW +: UW] = UW'(next_val);
      if (dv && k < dc) beat.push_back(next_val);
      next_val = (next_val + 1) & 16'hFFFF;
    end
    #1;
    take = fr && !m_busy && !fl && (m_buf.size() <= BD - SL);
    chk("R6 fetch_take", int'(fetch_take), int'(take));
    if (m_busy && !fl)
      for (int s = 0; s < m_st_cnt[m_rd_idx]; s++) pushed.push_back(m_st_dat[m_rd_idx][s]);
    if (m_wr_en) begin
      m_st_cnt[m_wr_idx] = m_wr_cnt;
      for (int s = 0; s < SL; s++) m_st_dat[m_wr_idx][s] = m_wr_dat[s];
    end
    if (fl) m_buf.delete();
    else begin
      for (int i = 0; i < IW && m_buf.size() > 0; i++) void'(m_buf.pop_front());
      foreach (pushed[j]) m_buf.push_back(pushed[j]);
    end
    m_busy = take;
    if (take) m_rd_idx = fi;
    m_wr_en = 0;
    if (fl) m_fill.delete();
    else if (dv) begin
      if (m_fill.size() + dc > SL) begin
        emit(m_fill);
        m_fill = beat;
      end else begin
        foreach (beat[j]) m_fill.push_back(beat[j]);
        if (m_fill.size() == SL) begin
          emit(m_fill);
          m_fill.delete();
        end
      end
    end else if (fe && m_fill.size() > 0) begin
      emit(m_fill);
      m_fill.delete();
    end
  endtask

  initial begin
    for (int i = 0; i < LN; i++) m_st_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset wr_en", int'(wr_en), 0);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset fetch_take", int'(fetch_take), 0);
    rst_n = 1'b1;
    // R2 exact fill: 2 + 4 = 6 slots
    step(1, 2, 0, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0);
    // R3 spill: 4 then 3 does not fit
    step(1, 4, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0);
    // R4 end of fill closes partial line of 3
    step(0, 0, 1, 0, 0, 0);
    // R4 fill_end together with a beat is ignored
    step(1, 2, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    // R4 fill_end on an empty line does nothing
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R6 R7 R8 held fetch requests, stall under shallow queue
    for (int c = 0; c < 16; c++) step(0, 0, 0, 1, c % LN, 0);
    // R9 flush while a fetch is in progress and a beat pending
    step(1, 3, 0, 1, 1, 0);
    step(1, 2, 0, 1, 2, 0);
    step(1, 1, 0, 1, 0, 1);
    step(1, 4, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    for (int c = 0; c < 4; c++) step(0, 0, 0, 0, 0, 0);
    // Random mix over all requirements
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      step(r < 55, $urandom_range(1, DW), $urandom_range(0, 9) == 0,
           $urandom_range(0, 2) != 0, $urandom_range(0, LN - 1), $urandom_range(0, 60) == 0);
    end
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule